// File: doc/BRIEF.md
# Fractional Tick Divider with Source Select

This block turns a stream of source clock-enable pulses into a slower stream of single-cycle ticks. The converter sequencer uses those ticks as its controller clock enable. One divider instance drives both the analog-to-digital and the digital-to-analog sequencers, so both receive exactly the same tick. Two source enables arrive on separate inputs, and a one-bit select picks which one is counted. The whole block lives in one clock domain and never switches real clocks.

The division ratio has an integer field N and a fraction A/B. A nominal period lasts N+1 counted source pulses. An accumulator adds A once per period. Whenever the accumulator reaches B, that period is stretched by one pulse and B is subtracted. The average period is therefore N + A/B + 1 source pulses. New field values are staged on a load strobe. They replace the active ones at the next period boundary, or at once while the divider is disabled, and the accumulator is cleared when they do.

Top module: `frac_tick_div`

## Requirements
- R1: After reset the tick output is low, and the active fields are N=15, A=0, B=1. With no load, every period is 16 counted source pulses.
- R2: With B nonzero and A < B, period k after the fields became active (k counted from 0) lasts N + 1 + floor((k+1)·A/B) − floor(k·A/B) counted pulses.
- R3: When B equals 0, A has no effect and every period lasts exactly N+1 counted pulses.
- R4: When src_sel is 0, only pulses on src_a_en are counted; when it is 1, only pulses on src_b_en are counted. Pulses on the unselected input never advance the divider.
- R5: While enable is low no tick is produced, and any partial period is discarded. After enable returns, the sequence restarts at period k=0 with a cleared accumulator.
- R6: The tick is high for exactly one cycle per period, in the cycle after the clock edge that sampled the final counted pulse of the period.
- R7: Fields presented with cfg_load while enabled do not alter the period in progress. They become active at the next period boundary, and the fractional sequence restarts from k=0. Fields loaded while disabled become active immediately.
- R8: If several loads occur within one period, only the last one becomes active. A load in the same cycle as a boundary is applied at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Divider run enable |
| src_sel | input | 1 | 0 selects src_a_en, 1 selects src_b_en |
| src_a_en | input | 1 | First source clock-enable pulse |
| src_b_en | input | 1 | Second source clock-enable pulse |
| cfg_load | input | 1 | Strobe that stages cfg_int, cfg_num, cfg_den |
| cfg_int | input | INT_W | Integer part N of the ratio |
| cfg_num | input | FRAC_W | Fraction numerator A |
| cfg_den | input | FRAC_W | Fraction denominator B (0 means no fraction) |
| tick | output | 1 | Single-cycle divided tick |

## Verification
The hardest case to reach is a stretched period whose boundary coincides with a load, or with a switch of the source select. In that case the old fraction, the staged fields and the accumulator clear all meet on the same edge. Directed stretches first pin down each ordering on its own: mid-period loads, repeated loads, loads while disabled, and a source swap. A long random run then uses dense pulses, small denominators and frequent loads, so these edges coincide many times. Each observed period is compared with the closed-form floor expression, which never models the accumulator.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  // Power-on ratio: 15 + 0/1 + 1 = 16 source pulses per tick
  localparam int unsigned DEF_INT = 15;
  localparam int unsigned DEF_NUM = 0;
  localparam int unsigned DEF_DEN = 1;

  // Whether the current period has already taken its extra pulse
  typedef enum logic {
    PH_BASE    = 1'b0,
    PH_STRETCH = 1'b1
  } phase_e;

endpackage

// File: rtl/fdiv_src_mux.sv
module fdiv_src_mux #(
  parameter int unsigned NSRC = 2,
  localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  src_en,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse
);

  always_comb begin
    pulse = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) begin
        pulse = src_en[i];
      end
    end
  end

endmodule

// File: rtl/fdiv_cfg_stage.sv
module fdiv_cfg_stage #(
  parameter int unsigned INT_W   = 8,
  parameter int unsigned FRAC_W  = 6,
  parameter int unsigned RST_INT = 15,
  parameter int unsigned RST_NUM = 0,
  parameter int unsigned RST_DEN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  in_int,
  input  logic [FRAC_W-1:0] in_num,
  input  logic [FRAC_W-1:0] in_den,
  input  logic              apply,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_num,
  output logic [FRAC_W-1:0] act_den,
  output logic              restart
);

  logic              pend_v_q, pend_v_d;
  logic [INT_W-1:0]  pend_int_q, pend_int_d;
  logic [FRAC_W-1:0] pend_num_q, pend_num_d;
  logic [FRAC_W-1:0] pend_den_q, pend_den_d;
  logic [INT_W-1:0]  act_int_q, act_int_d;
  logic [FRAC_W-1:0] act_num_q, act_num_d;
  logic [FRAC_W-1:0] act_den_q, act_den_d;

  always_comb begin
    pend_v_d   = pend_v_q;
    pend_int_d = pend_int_q;
    pend_num_d = pend_num_q;
    pend_den_d = pend_den_q;
    act_int_d  = act_int_q;
    act_num_d  = act_num_q;
    act_den_d  = act_den_q;
    restart    = apply & (load | pend_v_q);
    if (apply) begin
      pend_v_d = 1'b0;
      if (load) begin
        act_int_d = in_int;
        act_num_d = in_num;
        act_den_d = in_den;
      end else if (pend_v_q) begin
        act_int_d = pend_int_q;
        act_num_d = pend_num_q;
        act_den_d = pend_den_q;
      end
    end else if (load) begin
      pend_v_d   = 1'b1;
      pend_int_d = in_int;
      pend_num_d = in_num;
      pend_den_d = in_den;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_int_q <= '0;
      pend_num_q <= '0;
      pend_den_q <= '0;
      act_int_q  <= INT_W'(RST_INT);
      act_num_q  <= FRAC_W'(RST_NUM);
      act_den_q  <= FRAC_W'(RST_DEN);
    end else begin
      pend_v_q   <= pend_v_d;
      pend_int_q <= pend_int_d;
      pend_num_q <= pend_num_d;
      pend_den_q <= pend_den_d;
      act_int_q  <= act_int_d;
      act_num_q  <= act_num_d;
      act_den_q  <= act_den_d;
    end
  end

  assign act_int = act_int_q;
  assign act_num = act_num_q;
  assign act_den = act_den_q;

endmodule

// File: rtl/fdiv_frac_acc.sv
module fdiv_frac_acc #(
  parameter int unsigned FRAC_W = 6,
  localparam int unsigned SUM_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  input  logic              clear,
  input  logic              take_long,
  input  logic              take_short,
  output logic              owe,
  output logic [FRAC_W-1:0] acc
);

  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  sum_less;
  logic              den_zero;

  assign den_zero = (den == '0);
  assign sum      = {1'b0, acc_q} + {1'b0, num};
  assign sum_less = sum - {1'b0, den};
  assign owe      = !den_zero && (sum >= {1'b0, den});

  always_comb begin
    acc_d = acc_q;
    if (clear) begin
      acc_d = '0;
    end else if (take_long) begin
      acc_d = sum_less[FRAC_W-1:0];
    end else if (take_short) begin
      acc_d = den_zero ? '0 : sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/fdiv_period_cnt.sv
module fdiv_period_cnt
  import frac_tick_pkg::*;
#(
  parameter int unsigned INT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pulse,
  input  logic [INT_W-1:0] limit,
  input  logic             owe,
  output logic             boundary,
  output logic             take_long,
  output logic             tick,
  output logic [INT_W-1:0] cnt,
  output phase_e           phase
);

  logic [INT_W-1:0] cnt_q, cnt_d;
  phase_e           phase_q, phase_d;
  logic             tick_q;
  logic             at_end;

  assign at_end    = enable & pulse & (cnt_q == limit);
  assign take_long = at_end & (phase_q == PH_BASE) & owe;
  assign boundary  = at_end & ~take_long;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!enable) begin
      cnt_d   = '0;
      phase_d = PH_BASE;
    end else if (boundary) begin
      cnt_d   = '0;
      phase_d = PH_BASE;
    end else if (take_long) begin
      phase_d = PH_STRETCH;
    end else if (pulse) begin
      cnt_d = cnt_q + INT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_BASE;
      tick_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      tick_q  <= boundary;
    end
  end

  assign tick  = tick_q;
  assign cnt   = cnt_q;
  assign phase = phase_q;

endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
  import frac_tick_pkg::*;
#(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              src_sel,
  input  logic              src_a_en,
  input  logic              src_b_en,
  input  logic              cfg_load,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_num,
  input  logic [FRAC_W-1:0] cfg_den,
  output logic              tick
);

  localparam int unsigned NSRC = 2;

  logic              src_pulse;
  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_num;
  logic [FRAC_W-1:0] act_den;
  logic              restart;
  logic              apply;
  logic              boundary;
  logic              take_long;
  logic              take_short;
  logic              acc_clear;
  logic              owe;
  logic [FRAC_W-1:0] acc_val;
  logic [INT_W-1:0]  cnt_val;
  phase_e            phase_val;

  assign apply      = boundary | ~enable;
  assign acc_clear  = restart | ~enable;
  assign take_short = boundary & (phase_val == PH_BASE);

  fdiv_src_mux #(.NSRC(NSRC)) u_mux (
    .src_en ({src_b_en, src_a_en}),
    .sel    (src_sel),
    .pulse  (src_pulse)
  );

  fdiv_cfg_stage #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W),
    .RST_INT(DEF_INT),
    .RST_NUM(DEF_NUM),
    .RST_DEN(DEF_DEN)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .in_int  (cfg_int),
    .in_num  (cfg_num),
    .in_den  (cfg_den),
    .apply   (apply),
    .act_int (act_int),
    .act_num (act_num),
    .act_den (act_den),
    .restart (restart)
  );

  fdiv_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .num        (act_num),
    .den        (act_den),
    .clear      (acc_clear),
    .take_long  (take_long),
    .take_short (take_short),
    .owe        (owe),
    .acc        (acc_val)
  );

  fdiv_period_cnt #(.INT_W(INT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pulse     (src_pulse),
    .limit     (act_int),
    .owe       (owe),
    .boundary  (boundary),
    .take_long (take_long),
    .tick      (tick),
    .cnt       (cnt_val),
    .phase     (phase_val)
  );

endmodule

// File: rtl/frac_tick_div_chk.sv
module frac_tick_div_chk
  import frac_tick_pkg::*;
#(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              src_sel,
  input logic              src_a_en,
  input logic              src_b_en,
  input logic              tick,
  input logic [INT_W-1:0]  act_int,
  input logic [FRAC_W-1:0] act_num,
  input logic [FRAC_W-1:0] act_den,
  input logic [FRAC_W-1:0] acc_val,
  input logic [INT_W-1:0]  cnt_val,
  input phase_e            phase_val
);

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick); // R5

  AST_TICK_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(enable && (src_sel ? src_b_en : src_a_en))); // R6

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_val <= act_int); // R2

  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_den != '0 && act_num < act_den) |-> acc_val < act_den); // R2

  AST_NO_STRETCH_NO_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_den == '0) |-> (phase_val == PH_BASE)); // R3

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_int, act_num, act_den}) |-> (tick || !$past(enable))); // R7

endmodule

bind frac_tick_div frac_tick_div_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .src_sel   (src_sel),
  .src_a_en  (src_a_en),
  .src_b_en  (src_b_en),
  .tick      (tick),
  .act_int   (act_int),
  .act_num   (act_num),
  .act_den   (act_den),
  .acc_val   (acc_val),
  .cnt_val   (cnt_val),
  .phase_val (phase_val)
);

// File: tb/frac_tick_div_bench.sv
`timescale 1ns/1ps
module frac_tick_div_bench;

  localparam int unsigned INT_W  = 8;
  localparam int unsigned FRAC_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              enable, src_sel, src_a_en, src_b_en, cfg_load;
  logic [INT_W-1:0]  cfg_int;
  logic [FRAC_W-1:0] cfg_num, cfg_den;
  logic              tick;

  always #2.5 clk = ~clk;

  frac_tick_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_frac_tick_div (
    .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
    .src_a_en(src_a_en), .src_b_en(src_b_en), .cfg_load(cfg_load),
    .cfg_int(cfg_int), .cfg_num(cfg_num), .cfg_den(cfg_den), .tick(tick)
  );

  int checks = 0, fails = 0, cyc_n = 0, ntick = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  // previous drive
  bit p_en, p_sel, p_pa, p_pb, p_ld;
  int p_n, p_a, p_b;
  // model
  int cur_n = 15, cur_a = 0, cur_b = 1;
  int pend_n, pend_a, pend_b;
  bit pend_v = 1'b0;
  int k = 0, pcnt = 0;
  // directed globals
  bit g_en = 0, g_sel = 0;
  int amode = 0, bmode = 0;
  bit last_tick = 0;

  function automatic int exp_period(int n, int a, int b, int kk);
    if (b == 0) return n + 1;
    return n + 1 + ((kk + 1) * a) / b - (kk * a) / b;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic observe();
    int e;
    if (!p_en) begin
      check(tick == 1'b0, "R5 tick while disabled", int'(tick), 0);
      if (p_ld) begin cur_n = p_n; cur_a = p_a; cur_b = p_b; end
      else if (pend_v) begin cur_n = pend_n; cur_a = pend_a; cur_b = pend_b; end
      pend_v = 0; k = 0; pcnt = 0;
    end else begin
      if (p_sel ? p_pb : p_pa) pcnt++;
      if (p_ld) begin pend_n = p_n; pend_a = p_a; pend_b = p_b; pend_v = 1; end
      e = exp_period(cur_n, cur_a, cur_b, k);
      if (tick) begin
        ntick++;
        check(pcnt == e, {cur_req, " period length"}, pcnt, e);
        pcnt = 0;
        if (pend_v) begin
          cur_n = pend_n; cur_a = pend_a; cur_b = pend_b; pend_v = 0; k = 0;
        end else k++;
      end else if (pcnt > e) begin
        check(1'b0, {cur_req, " missing tick"}, pcnt, e);
        pcnt = 0; k++;
      end
    end
  endtask

  task automatic cyc(bit en, bit sel, bit pa, bit pb, bit ld, int n, int a, int b);
    @(negedge clk);
    cyc_n++;
    observe();
    if (cur_req == "R6") begin
      check(!(tick && last_tick), "R6 tick wider than one cycle", int'(tick), 0);
    end
    last_tick = tick;
    enable = en; src_sel = sel; src_a_en = pa; src_b_en = pb; cfg_load = ld;
    cfg_int = INT_W'(n); cfg_num = FRAC_W'(a); cfg_den = FRAC_W'(b);
    p_en = en; p_sel = sel; p_pa = pa; p_pb = pb; p_ld = ld;
    p_n = n; p_a = a; p_b = b;
  endtask

  function automatic bit pat(int mode);
    case (mode)
      1: return 1'b1;
      2: return cyc_n[0];
      3: return ($urandom % 4) != 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run(int ncyc);
    for (int i = 0; i < ncyc; i++) cyc(g_en, g_sel, pat(amode), pat(bmode), 0, 0, 0, 0);
  endtask

  task automatic load(int n, int a, int b);
    cyc(g_en, g_sel, pat(amode), pat(bmode), 1, n, a, b);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc_n);
    finish_run();
  end

  initial begin
    int t0;
    void'($urandom(32'd20240611));
    rst_n = 0; enable = 0; src_sel = 0; src_a_en = 0; src_b_en = 0;
    cfg_load = 0; cfg_int = '0; cfg_num = '0; cfg_den = '0;
    p_en = 0; p_sel = 0; p_pa = 0; p_pb = 0; p_ld = 0; p_n = 0; p_a = 0; p_b = 0;
    repeat (4) @(negedge clk);
    check(tick == 1'b0, "R1 tick during reset", int'(tick), 0);
    rst_n = 1;
    @(negedge clk);
    check(tick == 1'b0, "R1 tick after reset", int'(tick), 0);

    // R1: default ratio 16
    cur_req = "R1"; g_en = 1; g_sel = 0; amode = 1; bmode = 0;
    run(40);
    // R3: zero denominator ignores numerator
    cur_req = "R3"; load(2, 5, 0); run(30);
    // R2: fractional 1 + 3/5 + 1
    cur_req = "R2"; load(1, 3, 5); amode = 3; run(80);
    // R4: only selected source counts
    cur_req = "R4"; amode = 1; load(3, 0, 0); run(10);
    amode = 0; bmode = 1; t0 = ntick; run(40);
    check(ntick == t0, "R4 unselected source produced tick", ntick - t0, 0);
    g_sel = 1; run(40);
    check(ntick > t0, "R4 selected source produced no tick", ntick - t0, 1);
    g_sel = 0; amode = 1; bmode = 0; run(10);
    // R7: load mid-period and load while disabled
    cur_req = "R7"; load(7, 0, 0); run(20); run(3); load(1, 0, 0); run(30);
    g_en = 0; run(3); load(4, 1, 3); run(2); g_en = 1; run(60);
    // R8: last of several loads wins
    cur_req = "R8"; load(9, 0, 0); run(2); load(5, 0, 0); run(1); load(2, 1, 2); run(50);
    // R5: disable mid-period
    cur_req = "R5"; run(2); g_en = 0; run(10); g_en = 1; run(40);
    // R6: tick exactly one cycle after pulse, one cycle wide
    cur_req = "R6"; load(0, 0, 0); amode = 2; run(40);
    cur_req = "R2";
    // random phase
    for (int i = 0; i < 8000; i++) begin
      bit en, ld;
      int n, a, b;
      en = ($urandom % 150) != 0;
      if (($urandom % 300) == 0) g_sel = ~g_sel;
      ld = ($urandom % 60) == 0;
      n = $urandom % 6;
      b = $urandom % 8;
      a = (b != 0) ? int'($urandom % b) : int'($urandom % 64);
      cyc(en, g_sel, ($urandom % 4) != 0, ($urandom % 4) != 0, ld, n, a, b);
    end
    finish_run();
  end

endmodule